// File: doc/BRIEF.md
# Warp Reconvergence Mask Stack

This block keeps the active-thread mask of one warp consistent across structured branch divergence. The issue stage hands it one command per warp instruction: a split, which carries the per-thread bits of the chosen predicate together with the present thread mask and PC, or a join, which carries no operands. On a split it decides whether the active threads agree. If they agree, it records a single marker that only restores the mask later. If they disagree, it saves two entries and lets the threads whose predicate is false run first. A join pops the top entry, restores its mask and, for the taken-side entry, sends fetch to the stored PC.

A separate check watches every control-flow instruction. It counts the active threads and how many of them have the predicate set. It raises a fault when some of those threads would branch and others would not. All results are registered and appear one clock after the command. The nesting depth and the thread count are parameters.

Top module: `simt_reconv_stack`

## Requirements
- R1: While reset is high, and after it is released, mask_o is all ones, empty_o is 1, and full_o, redir_o, err_o and div_fault_o are 0.
- R2: cmd_i encodes 0 as idle, 1 as split, 2 as join and 3 as reserved. A split whose active threads (mask_i bit set) all carry the same pred_i value pushes one uniform entry and sets mask_o to mask_i, with no redirect. pred_i bits of inactive threads are ignored.
- R3: A split whose active threads disagree pushes a fall-through entry holding mask_i, then a taken entry holding mask_i & pred_i with pc_i. mask_o becomes mask_i & ~pred_i.
- R4: A join with a uniform entry on top sets mask_o to that entry's mask and pops it, with redir_o left at 0.
- R5: A join with a taken entry on top raises redir_o for one cycle with redir_pc_o equal to the stored PC. It sets mask_o to the stored mask and pops the entry.
- R6: A join with a fall-through entry on top sets mask_o to the stored mask and pops it, with no redirect.
- R7: A split with mask_i equal to zero raises div_fault_o for one cycle. It pushes nothing and leaves mask_o unchanged.
- R8: When br_i is 1, div_fault_o pulses exactly when the count of threads with both mask_i and pred_i set is nonzero and differs from the count of threads with mask_i set. mask_o is not affected.
- R9: A split that needs more free entries than remain (one for uniform, two for divergent) raises err_o for one cycle and changes neither the stack nor mask_o.
- R10: A join on an empty stack raises err_o for one cycle and leaves mask_o unchanged.
- R11: Idle and reserved commands leave mask_o and the stack unchanged.
- R12: full_o is 1 exactly when DEPTH entries are held, and empty_o is 1 exactly when none are held. Every output reflects a command one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 0 idle, 1 split, 2 join, 3 reserved |
| br_i | input | 1 | Present instruction is control flow; run the divergence check |
| pred_i | input | THREADS | Per-thread bits of the selected predicate |
| mask_i | input | THREADS | Current thread-active mask |
| pc_i | input | 32 | PC of the present instruction |
| mask_o | output | THREADS | Thread mask after the last split or join |
| redir_o | output | 1 | One-cycle fetch redirect request |
| redir_pc_o | output | 32 | Redirect target |
| err_o | output | 1 | Overflow or underflow pulse |
| div_fault_o | output | 1 | Divergence fault pulse |
| full_o | output | 1 | Stack holds DEPTH entries |
| empty_o | output | 1 | Stack holds no entries |

## Verification
A wrong entry kind or a stale stack pointer shows up on the next join. It appears as a missing or spurious redir_o, or as a mask_o that does not match the mask saved by the matching split, one cycle after that join. A miscounted depth appears at once on full_o and empty_o, and through err_o when an overflow or underflow goes unreported. Nested sequences pop every pushed entry and compare each restored mask and target. They also fill the stack to the brim, so that any error in the stored data or the pointer surfaces within a few commands.

// File: rtl/simt_rcv_pkg.sv
package simt_rcv_pkg;

    localparam int PC_W = 32;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic [1:0] {
        RC_IDLE  = 2'd0,
        RC_SPLIT = 2'd1,
        RC_JOIN  = 2'd2,
        RC_RSVD  = 2'd3
    } rc_cmd_e;

    typedef enum logic [1:0] {
        ENT_UNIFORM = 2'd0,
        ENT_TAKEN   = 2'd1,
        ENT_FALL    = 2'd2
    } ent_kind_e;

    localparam int KIND_W = 2;

endpackage

// File: rtl/rcv_vote.sv
module rcv_vote #(
    parameter int THREADS = 8
) (
    input  logic [THREADS-1:0] pred_i,
    input  logic [THREADS-1:0] mask_i,
    output logic               none_active_o,
    output logic               uniform_o,
    output logic [THREADS-1:0] taken_mask_o,
    output logic [THREADS-1:0] fall_mask_o,
    output logic               br_diverge_o
);
    localparam int CNT_W = $clog2(THREADS + 1);

    logic [CNT_W-1:0] n_active;
    logic [CNT_W-1:0] n_enabled;

    always_comb begin
        taken_mask_o  = mask_i & pred_i;
        fall_mask_o   = mask_i & ~pred_i;
        none_active_o = (mask_i == '0);
        uniform_o     = (taken_mask_o == '0) || (taken_mask_o == mask_i);
        n_active      = CNT_W'($countones(mask_i));
        n_enabled     = CNT_W'($countones(taken_mask_o));
        br_diverge_o  = (n_enabled != '0) && (n_enabled != n_active);
    end
endmodule

// File: rtl/rcv_stack.sv
module rcv_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_a,
    input  logic                         push_b,
    input  logic                         pop,
    input  logic [W-1:0]                 din_a,
    input  logic [W-1:0]                 din_b,
    output logic [W-1:0]                 top_o,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slot_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] wr0;
    logic [AW-1:0] wr1;
    logic [AW-1:0] rd;

    assign wr0   = AW'(cnt_q);
    assign wr1   = AW'(cnt_q + CW'(1));
    assign rd    = AW'(cnt_q - CW'(1));
    assign top_o = slot_q[rd];
    assign cnt_o = cnt_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_a && wr0 == AW'(i)) begin
                slot_q[i] <= din_a;
            end else if (push_b && wr1 == AW'(i)) begin
                slot_q[i] <= din_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (pop) begin
            cnt_q <= cnt_q - CW'(1);
        end else if (push_b) begin
            cnt_q <= cnt_q + CW'(2);
        end else if (push_a) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_rcv_pkg::*;
#(
    parameter int THREADS = 8,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cmd_i,
    input  logic               br_i,
    input  logic [THREADS-1:0] pred_i,
    input  logic [THREADS-1:0] mask_i,
    input  logic [31:0]        pc_i,
    output logic [THREADS-1:0] mask_o,
    output logic               redir_o,
    output logic [31:0]        redir_pc_o,
    output logic               err_o,
    output logic               div_fault_o,
    output logic               full_o,
    output logic               empty_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        ent_kind_e          kind;
        logic [THREADS-1:0] mask;
        pc_t                pc;
    } entry_t;

    localparam int EW = $bits(entry_t);

    rc_cmd_e            cmd;
    logic               none_active, uniform, br_diverge;
    logic [THREADS-1:0] taken_mask, fall_mask;
    logic [EW-1:0]      top_raw;
    entry_t             top, ent_a, ent_b;
    logic [CW-1:0]      cnt;
    logic               room1, room2;
    logic               push_a, push_b, pop;
    logic               split_err, join_err, split_idle_fault;

    logic [THREADS-1:0] mask_q;
    logic               redir_q, err_q, fault_q;
    pc_t                rpc_q;

    rcv_vote #(.THREADS(THREADS)) u_vote (
        .pred_i        (pred_i),
        .mask_i        (mask_i),
        .none_active_o (none_active),
        .uniform_o     (uniform),
        .taken_mask_o  (taken_mask),
        .fall_mask_o   (fall_mask),
        .br_diverge_o  (br_diverge)
    );

    rcv_stack #(.W(EW), .DEPTH(DEPTH)) u_stk (
        .clk    (clk),
        .rst    (rst),
        .push_a (push_a),
        .push_b (push_b),
        .pop    (pop),
        .din_a  (ent_a),
        .din_b  (ent_b),
        .top_o  (top_raw),
        .cnt_o  (cnt)
    );

    always_comb begin
        cmd   = rc_cmd_e'(cmd_i);
        top   = entry_t'(top_raw);
        room1 = (int'(cnt) + 1) <= DEPTH;
        room2 = (int'(cnt) + 2) <= DEPTH;

        ent_a.kind = uniform ? ENT_UNIFORM : ENT_FALL;
        ent_a.mask = mask_i;
        ent_a.pc   = pc_i;
        ent_b.kind = ENT_TAKEN;
        ent_b.mask = taken_mask;
        ent_b.pc   = pc_i;

        split_idle_fault = (cmd == RC_SPLIT) && none_active;
        push_a = (cmd == RC_SPLIT) && !none_active && (uniform ? room1 : room2);
        push_b = push_a && !uniform;
        split_err = (cmd == RC_SPLIT) && !none_active && !push_a;
        pop      = (cmd == RC_JOIN) && (cnt != '0);
        join_err = (cmd == RC_JOIN) && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            redir_q <= 1'b0;
            rpc_q   <= '0;
            err_q   <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            redir_q <= 1'b0;
            err_q   <= split_err || join_err;
            fault_q <= split_idle_fault || (br_i && br_diverge);
            if (push_b) begin
                mask_q <= fall_mask;
            end else if (push_a) begin
                mask_q <= mask_i;
            end else if (pop) begin
                mask_q <= top.mask;
                if (top.kind == ENT_TAKEN) begin
                    redir_q <= 1'b1;
                    rpc_q   <= top.pc;
                end
            end
        end
    end

    assign mask_o      = mask_q;
    assign redir_o     = redir_q;
    assign redir_pc_o  = rpc_q;
    assign err_o       = err_q;
    assign div_fault_o = fault_q;
    assign full_o      = (int'(cnt) == DEPTH);
    assign empty_o     = (cnt == '0);
endmodule

// File: rtl/rcv_chk.sv
module rcv_chk #(
    parameter int THREADS = 8,
    parameter int DEPTH   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         cmd_i,
    input logic               br_i,
    input logic [THREADS-1:0] pred_i,
    input logic [THREADS-1:0] mask_i,
    input logic [31:0]        pc_i,
    input logic [THREADS-1:0] mask_o,
    input logic               redir_o,
    input logic [31:0]        redir_pc_o,
    input logic               err_o,
    input logic               div_fault_o,
    input logic               full_o,
    input logic               empty_o
);
    // R12
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

    // R5
    redirect_after_join_chk: assert property (@(posedge clk) disable iff (rst)
        redir_o |-> ($past(cmd_i) == 2'd2));

    // R10
    join_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'd2 && empty_o) |=> (err_o && $stable(mask_o)));

    // R9
    split_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'd1 && full_o && mask_i != '0) |=> (err_o && full_o && $stable(mask_o)));

    // R7
    idle_split_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'd1 && mask_i == '0) |=> (div_fault_o && $stable(mask_o)));

    // R11
    hold_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'd0 || cmd_i == 2'd3) |=> ($stable(mask_o) && !redir_o && !err_o));
endmodule

bind simt_reconv_stack rcv_chk #(.THREADS(THREADS), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_simt_reconv_stack.sv
`timescale 1ns/100ps
module sim_simt_reconv_stack;
    localparam int T = 8;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cmd_i = 2'd0;
    logic         br_i = 1'b0;
    logic [T-1:0] pred_i = '0;
    logic [T-1:0] mask_i = '0;
    logic [31:0]  pc_i = '0;
    logic [T-1:0] mask_o;
    logic         redir_o, err_o, div_fault_o, full_o, empty_o;
    logic [31:0]  redir_pc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    simt_reconv_stack #(.THREADS(T), .DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .br_i(br_i), .pred_i(pred_i),
        .mask_i(mask_i), .pc_i(pc_i), .mask_o(mask_o), .redir_o(redir_o),
        .redir_pc_o(redir_pc_o), .err_o(err_o), .div_fault_o(div_fault_o),
        .full_o(full_o), .empty_o(empty_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  cmd;
        logic        br;
        logic [7:0]  pred;
        logic [7:0]  mask;
        logic [31:0] pc;
        logic [7:0]  emask;
        logic        eredir;
        logic [31:0] epc;
        logic        eerr;
        logic        efault;
        logic        eempty;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'd2,  2'd1, 1'b0, 8'hFF, 8'h0F, 32'h100, 8'h0F, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R2 uniform
        '{8'd3,  2'd1, 1'b0, 8'h05, 8'h0F, 32'h200, 8'h0A, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R3 divergent
        '{8'd5,  2'd2, 1'b0, 8'h00, 8'h00, 32'h0,   8'h05, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0}, // R5 taken side
        '{8'd6,  2'd2, 1'b0, 8'h00, 8'h00, 32'h0,   8'h0F, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R6 fall-through
        '{8'd4,  2'd2, 1'b0, 8'h00, 8'h00, 32'h0,   8'h0F, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1}, // R4 uniform pop
        '{8'd10, 2'd2, 1'b0, 8'h00, 8'h00, 32'h0,   8'h0F, 1'b0, 32'h0,   1'b1, 1'b0, 1'b1}, // R10 underflow
        '{8'd7,  2'd1, 1'b0, 8'h00, 8'h00, 32'h400, 8'h0F, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1}, // R7 no active
        '{8'd8,  2'd0, 1'b1, 8'h03, 8'h0F, 32'h0,   8'h0F, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1}, // R8 disagree
        '{8'd8,  2'd0, 1'b1, 8'h00, 8'h0F, 32'h0,   8'h0F, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1}, // R8 none taken
        '{8'd8,  2'd0, 1'b1, 8'hFF, 8'h0F, 32'h0,   8'h0F, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1}, // R8 all taken
        '{8'd2,  2'd1, 1'b0, 8'h0F, 8'hF0, 32'h300, 8'hF0, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R2 inactive preds
        '{8'd11, 2'd3, 1'b0, 8'h00, 8'h00, 32'h0,   8'hF0, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R11 reserved
        '{8'd2,  2'd1, 1'b0, 8'h00, 8'h3C, 32'h500, 8'h3C, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R2 all false
        '{8'd4,  2'd2, 1'b0, 8'h00, 8'h00, 32'h0,   8'h3C, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R4
        '{8'd4,  2'd2, 1'b0, 8'h00, 8'h00, 32'h0,   8'hF0, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1}  // R4 outer
    };

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c, input logic b, input logic [7:0] p,
                         input logic [7:0] m, input logic [31:0] pc);
        @(negedge clk);
        cmd_i = c; br_i = b; pred_i = p; mask_i = m; pc_i = pc;
        @(negedge clk);
        cmd_i = 2'd0; br_i = 1'b0; pred_i = '0; mask_i = '0; pc_i = '0;
    endtask

    task automatic check_reset(input string tag);
        check(tag, "mask", 32'(mask_o), 32'hFF);
        check(tag, "empty", 32'(empty_o), 1);
        check(tag, "full", 32'(full_o), 0);
        check(tag, "redir", 32'(redir_o), 0);
        check(tag, "err", 32'(err_o), 0);
        check(tag, "fault", 32'(div_fault_o), 0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_reset("R1 after reset");

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VEC[i].req, i);
            issue(VEC[i].cmd, VEC[i].br, VEC[i].pred, VEC[i].mask, VEC[i].pc);
            check(tg, "mask", 32'(mask_o), 32'(VEC[i].emask));
            check(tg, "redir", 32'(redir_o), 32'(VEC[i].eredir));
            if (VEC[i].eredir) check(tg, "redir_pc", redir_pc_o, VEC[i].epc);
            check(tg, "err", 32'(err_o), 32'(VEC[i].eerr));
            check(tg, "fault", 32'(div_fault_o), 32'(VEC[i].efault));
            check(tg, "empty", 32'(empty_o), 32'(VEC[i].eempty));
        end

        // R9 / R12: fill the stack
        for (int i = 0; i < D - 1; i++) begin
            issue(2'd1, 1'b0, 8'h00, 8'(i + 1), 32'h0);
        end
        check("R12 seven held", "full", 32'(full_o), 0);
        check("R12 seven held", "empty", 32'(empty_o), 0);
        issue(2'd1, 1'b0, 8'h01, 8'h03, 32'h600);   // needs two, one left
        check("R9 divergent no room", "err", 32'(err_o), 1);
        check("R9 divergent no room", "mask", 32'(mask_o), 32'h07);
        check("R9 divergent no room", "full", 32'(full_o), 0);
        issue(2'd1, 1'b0, 8'hFF, 8'hAA, 32'h700);
        check("R12 last slot", "full", 32'(full_o), 1);
        check("R12 last slot", "mask", 32'(mask_o), 32'hAA);
        issue(2'd1, 1'b0, 8'h00, 8'h77, 32'h800);
        check("R9 full", "err", 32'(err_o), 1);
        check("R9 full", "mask", 32'(mask_o), 32'hAA);
        check("R9 full", "full", 32'(full_o), 1);
        issue(2'd2, 1'b0, 8'h00, 8'h00, 32'h0);
        check("R9 top intact", "mask", 32'(mask_o), 32'hAA);
        check("R9 top intact", "full", 32'(full_o), 0);
        issue(2'd2, 1'b0, 8'h00, 8'h00, 32'h0);
        check("R9 below intact", "mask", 32'(mask_o), 32'h07);
        check("R9 below intact", "redir", 32'(redir_o), 0);

        // R3 nested divergence on top of uniform entries, then unwind
        issue(2'd1, 1'b0, 8'hA0, 8'hF0, 32'h900);
        check("R3 nested", "mask", 32'(mask_o), 32'h50);
        issue(2'd2, 1'b0, 8'h00, 8'h00, 32'h0);
        check("R5 nested", "redir", 32'(redir_o), 1);
        check("R5 nested", "redir_pc", redir_pc_o, 32'h900);
        check("R5 nested", "mask", 32'(mask_o), 32'hA0);
        issue(2'd2, 1'b0, 8'h00, 8'h00, 32'h0);
        check("R6 nested", "mask", 32'(mask_o), 32'hF0);
        check("R6 nested", "redir", 32'(redir_o), 0);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset("R1 mid-run reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule